// File: doc/BRIEF.md
# Serial Clock Divider with Standalone Timer Mode

This block derives the serial clock of an SPI master from the system clock. A 16-bit divide value is built from two byte registers, written separately through byte strobes. A down-counter clocked directly by the system clock runs for that many cycles, toggles the serial clock when it reaches terminal count and starts again from the divide value. Each toggle gives one half period, so the serial clock runs at the system clock divided by twice the divide value. A divide value of zero stands for 65536, which gives the slowest rate: one serial clock period per 131072 system clocks.

When the serial interface is switched off, the same counter can serve as a general 16-bit timer. The timer-function control bit selects this. Every terminal count then sets a sticky interrupt flag, which a dedicated write-one-to-clear input removes. The timer-function bit has no effect while the interface is enabled. The serial clock idles low whenever the interface is off.

Top module: `spi_rate_gen`

## Requirements
- R1: A cycle with `wr_lo` high loads `wdata` into the low byte of the divide value, and a cycle with `wr_hi` high loads it into the high byte. The divide value is {high byte, low byte}.
- R2: With `if_en` high, `sclk` toggles once every N system clocks, where N is the divide value (1 to 65535). The first toggle comes N clocks after the edge at which `if_en` is first sampled high.
- R3: A divide value of 0 is taken as N = 65536, so one full `sclk` period lasts 131072 clocks.
- R4: A byte write while the counter is running leaves the half period in progress unchanged. The new value is used from the next terminal count on.
- R5: Whenever `if_en` is sampled low, `sclk` is low from the next clock on.
- R6: With `if_en` low and `tmr_en` high, `irq` is set every N clocks after timer mode is entered. Once set, `irq` stays high until it is cleared.
- R7: While `if_en` is high, `tmr_en` is ignored and `irq` is never set.
- R8: `irq_clr` high in a cycle clears `irq` at the next edge. A terminal count in timer mode in the same cycle wins, and `irq` stays set.
- R9: After reset, `sclk` and `irq` are low and both divide bytes are zero.
- R10: Each change of mode (off, serial, timer) restarts the count from the full divide value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the low divide byte |
| wr_hi | input | 1 | Write strobe for the high divide byte |
| wdata | input | 8 | Byte write data |
| if_en | input | 1 | Serial interface enable |
| tmr_en | input | 1 | Timer-function enable (ignored while `if_en` is high) |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| sclk | output | 1 | Serial clock, idle low |
| irq | output | 1 | Sticky timer interrupt flag |

## Verification
On every cycle, the assertions check the mode gating: `sclk` falls and stays low once the interface is off, `sclk` rises only after the interface was enabled, `irq` rises only in timer mode, `irq` is sticky until cleared, and a clear always takes effect when no timer event can compete with it. The exact toggle spacing, the zero-means-65536 rule, the deferred effect of byte writes during a count, the restart on a mode change and the priority of a set over a simultaneous clear depend on the count history. Only the bench shows these, through its cycle-accurate reference model and its timed scenarios.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SERIAL = 2'd1,
    MODE_TIMER  = 2'd2
  } rate_mode_e;
endpackage

// File: rtl/spi_rate_rst_sync.sv
module spi_rate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/spi_rate_reload.sv
module spi_rate_reload #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int VAL_W    = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BYTES-1:0] lane_wr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [VAL_W-1:0]     reload
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic [BYTE_W-1:0] lane_d;

    always_comb begin
      lane_d = lane_wr[g] ? wdata : lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign reload[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/spi_rate_counter.sv
module spi_rate_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic             term
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Holding reload-1 makes a reload of zero wrap to all ones, i.e. 2**CNT_W cycles.
  always_comb begin
    term   = !load && (cnt_q == '0);
    cnt_en = 1'b1;
    if (load || term) cnt_d = reload - CNT_W'(1);
    else              cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_rate_out.sv
module spi_rate_out
  import spi_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rate_mode_e mode_now,
  input  logic       load,
  input  logic       term,
  input  logic       irq_clr,
  output logic       sclk,
  output logic       irq
);
  logic sclk_q, sclk_d;
  logic irq_q, irq_d;

  always_comb begin
    if (mode_now != MODE_SERIAL || load) sclk_d = 1'b0;
    else if (term)                       sclk_d = ~sclk_q;
    else                                 sclk_d = sclk_q;

    if (mode_now == MODE_TIMER && term)  irq_d = 1'b1;
    else if (irq_clr)                    irq_d = 1'b0;
    else                                 irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      irq_q  <= irq_d;
    end
  end

  assign sclk = sclk_q;
  assign irq  = irq_q;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              if_en,
  input  logic              tmr_en,
  input  logic              irq_clr,
  output logic              sclk,
  output logic              irq
);
  localparam int NUM_BYTES = 2;
  localparam int CNT_W     = BYTE_W * NUM_BYTES;

  logic             rst_n_int;
  logic [CNT_W-1:0] reload;
  rate_mode_e       mode_now, mode_q;
  logic             load, term;

  spi_rate_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  spi_rate_reload #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_reload (
    .clk(clk), .rst_n(rst_n_int), .lane_wr({wr_hi, wr_lo}),
    .wdata(wdata), .reload(reload)
  );

  // The interface enable takes precedence: timer mode only when it is off.
  always_comb begin
    if (if_en)       mode_now = MODE_SERIAL;
    else if (tmr_en) mode_now = MODE_TIMER;
    else             mode_now = MODE_IDLE;
    load = (mode_now == MODE_IDLE) || (mode_now != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) mode_q <= MODE_IDLE;
    else            mode_q <= mode_now;
  end

  spi_rate_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .load(load), .reload(reload), .term(term)
  );

  spi_rate_out u_out (
    .clk(clk), .rst_n(rst_n_int), .mode_now(mode_now), .load(load),
    .term(term), .irq_clr(irq_clr), .sclk(sclk), .irq(irq)
  );
endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic if_en,
  input logic tmr_en,
  input logic irq_clr,
  input logic sclk,
  input logic irq
);
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> !sclk);

  assert_sclk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(if_en));

  assert_no_irq_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (if_en && !irq) |=> !irq);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_from_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(!if_en && tmr_en));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && (if_en || !tmr_en)) |=> !irq);
endmodule

bind spi_rate_gen spi_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .tmr_en(tmr_en),
  .irq_clr(irq_clr), .sclk(sclk), .irq(irq)
);

// File: tb/spi_rate_gen_test.sv
`timescale 1ns/1ps
module spi_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wdata = '0;
  logic       if_en = 1'b0, tmr_en = 1'b0, irq_clr = 1'b0;
  logic       sclk, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
    .if_en(if_en), .tmr_en(tmr_en), .irq_clr(irq_clr), .sclk(sclk), .irq(irq)
  );

  // Behavioural reference: elapsed cycles since the last (re)start.
  int  m_hi, m_lo, m_prev_mode, m_elapsed, m_period;
  bit  m_sclk, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_prev_mode = 0; m_elapsed = 0; m_period = 65536;
      m_sclk = 0; m_irq = 0;
    end else begin
      int mode, div;
      bit ev;
      mode = if_en ? 1 : (tmr_en ? 2 : 0);
      div  = (m_hi * 256 + m_lo == 0) ? 65536 : m_hi * 256 + m_lo;
      ev   = 0;
      if (mode == 0 || mode != m_prev_mode) begin
        m_elapsed = 0; m_period = div; m_sclk = 0;
      end else if (m_elapsed == m_period - 1) begin
        m_elapsed = 0; m_period = div; ev = 1;
      end else begin
        m_elapsed++;
      end
      if (mode != 1) m_sclk = 0;
      else if (ev)   m_sclk = ~m_sclk;
      if (mode == 2 && ev) m_irq = 1;
      else if (irq_clr)    m_irq = 0;
      m_prev_mode = mode;
      if (wr_hi) m_hi = wdata;
      if (wr_lo) m_lo = wdata;
    end
  end

  // Per-cycle comparison against the model (R2 R3 R4 R6 R10).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sclk !== m_sclk || irq !== m_irq) begin
        errors++;
        if (errors < 10)
          $display("FAIL model R2/R6: sclk=%0b irq=%0b expected sclk=%0b irq=%0b at %0t",
                   sclk, irq, m_sclk, m_irq, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_div(input int val);
    wdata = val[15:8]; wr_hi = 1'b1; @(negedge clk); wr_hi = 1'b0;
    wdata = val[7:0];  wr_lo = 1'b1; @(negedge clk); wr_lo = 1'b0;
  endtask

  // Negedges until sclk changes.
  task automatic wait_sclk(output int n);
    logic prev;
    prev = sclk; n = 0;
    do begin @(negedge clk); n++; end while (sclk == prev && n < 70000);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && n < 1000);
  endtask

  initial begin
    fork
      begin
        int n;
        cycles(3);
        rst_n = 1'b1;
        cycles(5);
        check("R9 sclk after reset", sclk, 0);
        check("R9 irq after reset", irq, 0);

        // R1/R2: divide 5 via high and low byte writes
        write_div(16'h0005);
        if_en = 1'b1;
        wait_sclk(n); check("R2 first toggle", n, 6);
        wait_sclk(n); check("R2 half period", n, 5);
        // R4: change mid-run; current half period keeps 5
        write_div(16'h0003);
        wait_sclk(n); check("R4 current half unchanged", n, 3);
        wait_sclk(n); check("R4 new half period", n, 3);
        // R1: high byte matters: 0x0102 = 258
        write_div(16'h0102);
        wait_sclk(n); wait_sclk(n); check("R1 high byte in divide", n, 258);

        // R7: timer bit ignored while serial enabled
        write_div(16'h0004);
        tmr_en = 1'b1;
        cycles(40);
        check("R7 no irq in serial mode", irq, 0);

        // R5: interface off -> sclk low
        tmr_en = 1'b0; if_en = 1'b0;
        cycles(1);
        check("R5 sclk low when off", sclk, 0);
        cycles(20);
        check("R5 sclk stays low", sclk, 0);

        // R6: timer mode
        tmr_en = 1'b1;
        wait_irq(n); check("R6 first timeout", n, 5);
        cycles(3);
        irq_clr = 1'b1;
        cycles(1);
        check("R8 set wins over clear", irq, 1);
        cycles(1);
        irq_clr = 1'b0;
        check("R8 clear", irq, 0);
        wait_irq(n); check("R6 timeout period", n, 3);
        cycles(10);
        check("R6 irq sticky", irq, 1);
        irq_clr = 1'b1; cycles(1); irq_clr = 1'b0;

        // R10: switch timer -> serial restarts the count
        if_en = 1'b1;
        wait_sclk(n); check("R10 restart on mode change", n, 5);
        if_en = 1'b0; tmr_en = 1'b0;
        cycles(2);

        // R3: divide 0 means 65536
        write_div(16'h0000);
        if_en = 1'b1;
        wait_sclk(n); check("R3 zero divide half period", n, 65537);
        if_en = 1'b0;
        cycles(2);
        check("R5 sclk low after disable", sclk, 0);
      end
      begin
        cycles(150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule